// File: doc/BRIEF.md
# Microprogram Sequencer with Opcode Dispatch Table

This block is the control core of a microprogrammed 8-bit processor. It holds the microprogram counter, a single return-address register, the instruction register and the interrupt-enable bit. It reads a 512-word by 32-bit microcode store and decodes the control fields of each word into next-address choices and timed strobes for the datapath. The datapath, the ALU and the register bank are separate blocks and are not part of it.

The store has two halves. Words 0 to 255 are ordinary microinstructions. Words 256 to 511 form the opcode decoder. Each of these words is a subroutine call built from a per-opcode target byte. A decode microinstruction latches the opcode and sends the next fetch to 256 plus that opcode. Every microinstruction takes two clock cycles. Bus-address and I/O strobes are driven in the first cycle. Read and write strobes are driven in the second cycle. The next address is chosen at the end of the second cycle.

The store contents are set at elaboration through two parameters. The first is the image of the lower half. The second is the list of opcode targets, from which the upper-half call words are computed.

Top module: `useq_core`

## Requirements
- R1: A synchronous active-low reset sets the microaddress to 0, the cycle phase to 0 (first cycle), the interrupt enable to 0 and the instruction register to 0.
- R2: Each microinstruction lasts exactly two clocks. `phase` alternates 0,1, and the microaddress changes only on the clock edge that ends phase 1.
- R3: A word whose flow field (bits 28..26) is 000, 101, 110 or 111, and whose group-1 field (bits 31..29) is neither 001 nor 111, continues at the microaddress plus one.
- R4: Flow field 001 (end) continues at microaddress 3.
- R5: Group-1 value 111 (halt) continues at microaddress 7 and leaves the return register unchanged.
- R6: Flow field 010 (call) saves the microaddress plus one and jumps to the 8-bit target in the lower half. The target's bits 7..6 sit in word bits 11..10 and its bits 5..0 in word bits 5..0.
- R7: Flow field 100 (conditional call) acts like R6 when `cond` is 1. When `cond` is 0 it continues at the microaddress plus one.
- R8: Flow field 011 (return) continues at the address held in the return register.
- R9: Group-1 value 001 (decode) loads `din` into the instruction register and continues at 256 plus `din`. The word found there is a call to that opcode's configured target.
- R10: Lower-half words that the program image does not set hold 0x04000000 and behave as an end word.
- R11: `vma` (word bit 25) and `io` (group-1 value 100) are asserted only in phase 0. `rd` (flow 101) and `wr` (flow 110) are asserted only in phase 1.
- R12: Group-1 value 011 sets the interrupt enable and value 010 clears it, both at the end of the microinstruction.
- R13: `aux_sel` (group-1 value 101), `clr_t1` (group-1 value 110), `set_acy` (flow 111) and `ld_al` (word bit 24) are asserted only in phase 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| din | input | 8 | Data input, used as the opcode by decode words |
| cond | input | 1 | Condition for conditional calls |
| uaddr | output | 9 | Current microaddress |
| uword | output | 32 | Current microinstruction word |
| phase | output | 1 | 0 = first cycle, 1 = second cycle |
| vma | output | 1 | Memory address valid / address-register load, first cycle |
| io | output | 1 | I/O cycle strobe, first cycle |
| rd | output | 1 | Read strobe, second cycle |
| wr | output | 1 | Write strobe, second cycle |
| aux_sel | output | 1 | Use aux carry for this operation, first cycle |
| clr_t1 | output | 1 | Clear T1 at end of first cycle |
| set_acy | output | 1 | Set aux carry at start of first cycle |
| ld_al | output | 1 | Load low address latch, first cycle |
| inte | output | 1 | Interrupt enable state |
| ir | output | 8 | Instruction register |

## Verification
The bench builds the block with its own lower-half image and its own opcode target list. Opcode 0x00 dispatches to 0x40, opcode 0x5A to 0x80, and every other opcode to address 3. These values place every group-1 and flow encoding on a reachable path: a nested call and return, a conditional call both taken and not taken, and a halt loop. In that loop the halt vector holds a return word, so a halt that wrongly saved a return address would send the flow elsewhere. One path falls onto an unset lower-half slot and so exercises the default end word.

// File: rtl/useq_pkg.sv
// Package: shared constants, field types and word builders for the
// microprogram sequencer. Assumes the fixed 32-bit word format below.
package useq_pkg;
    localparam int WORD_W   = 32;
    localparam int UADDR_W  = 9;
    localparam int TGT_W    = UADDR_W - 1;
    localparam int HALF     = 2 ** TGT_W;
    localparam int OPC_W    = 8;

    // Field positions inside a microinstruction word
    localparam int G1_HI    = 31;
    localparam int G2_HI    = 28;
    localparam int BIT_ADDR = 25;
    localparam int BIT_AL   = 24;

    localparam logic [UADDR_W-1:0] END_VEC  = 9'd3;
    localparam logic [UADDR_W-1:0] HALT_VEC = 9'd7;
    localparam logic [WORD_W-1:0]  END_WORD = 32'h0400_0000;

    typedef enum logic [2:0] {
        G1_NONE = 3'b000, G1_DECODE = 3'b001, G1_DI   = 3'b010, G1_EI   = 3'b011,
        G1_IO   = 3'b100, G1_AUX    = 3'b101, G1_CLRT = 3'b110, G1_HALT = 3'b111
    } grp1_e;

    typedef enum logic [2:0] {
        G2_NONE = 3'b000, G2_END = 3'b001, G2_CALL = 3'b010, G2_RET   = 3'b011,
        G2_TCALL = 3'b100, G2_RD = 3'b101, G2_WR   = 3'b110, G2_SETAC = 3'b111
    } grp2_e;

    // Build a (conditional) call word with the split target field
    function automatic logic [WORD_W-1:0] call_word(input grp2_e kind,
                                                    input logic [TGT_W-1:0] tgt);
        call_word = {3'b000, kind, 14'd0, tgt[7:6], 4'd0, tgt[5:0]};
    endfunction

    // Extract the split target field from a word
    function automatic logic [TGT_W-1:0] word_target(input logic [WORD_W-1:0] w);
        word_target = {w[11:10], w[5:0]};
    endfunction
endpackage

// File: rtl/useq_rom.sv
// Microcode store: lower half from PROG image, upper half computed as one
// call word per opcode from the JT target list. Purely combinational read.
module useq_rom
    import useq_pkg::*;
#(
    parameter logic [HALF*WORD_W-1:0] PROG = {HALF{END_WORD}},
    parameter logic [HALF*TGT_W-1:0]  JT   = {HALF{8'd3}}
) (
    input  logic [UADDR_W-1:0] addr,
    output logic [WORD_W-1:0]  word
);
    logic [TGT_W-1:0] idx;
    assign idx = addr[TGT_W-1:0];

    // Select microinstruction or dispatch word
    always_comb begin
        if (addr[UADDR_W-1])
            word = call_word(G2_CALL, JT[idx*TGT_W +: TGT_W]);
        else
            word = PROG[idx*WORD_W +: WORD_W];
    end
endmodule

// File: rtl/useq_flagdec.sv
// Strobe decoder: turns the control fields of the current word and the
// cycle phase into the timed datapath strobes. Combinational only.
module useq_flagdec
    import useq_pkg::*;
(
    input  logic  phase,
    input  grp1_e g1,
    input  grp2_e g2,
    input  logic  b_addr,
    input  logic  b_al,
    output logic  vma,
    output logic  io,
    output logic  rd,
    output logic  wr,
    output logic  aux_sel,
    output logic  clr_t1,
    output logic  set_acy,
    output logic  ld_al
);
    // First-cycle strobes
    always_comb begin
        vma     = !phase && b_addr;
        io      = !phase && (g1 == G1_IO);
        aux_sel = !phase && (g1 == G1_AUX);
        clr_t1  = !phase && (g1 == G1_CLRT);
        set_acy = !phase && (g2 == G2_SETAC);
        ld_al   = !phase && b_al;
    end

    // Second-cycle strobes
    always_comb begin
        rd = phase && (g2 == G2_RD);
        wr = phase && (g2 == G2_WR);
    end
endmodule

// File: rtl/useq_next.sv
// Sequencing state: phase, microaddress, return register, instruction
// register and interrupt enable. Decisions are taken at the end of phase 1.
module useq_next
    import useq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  grp1_e              g1,
    input  grp2_e              g2,
    input  logic [TGT_W-1:0]   tgt,
    input  logic [OPC_W-1:0]   din,
    input  logic               cond,
    output logic [UADDR_W-1:0] upc,
    output logic [UADDR_W-1:0] ret,
    output logic [OPC_W-1:0]   ir,
    output logic               phase,
    output logic               inte
);
    logic [UADDR_W-1:0] upc_inc;
    logic [UADDR_W-1:0] upc_nx;
    logic               save_ret;

    assign upc_inc = upc + 9'd1;

    // Next-address selection with decode and halt ahead of the flow field
    always_comb begin
        save_ret = 1'b0;
        upc_nx   = upc_inc;
        if (g1 == G1_DECODE)
            upc_nx = {1'b1, din};
        else if (g1 == G1_HALT)
            upc_nx = HALT_VEC;
        else begin
            case (g2)
                G2_END:  upc_nx = END_VEC;
                G2_RET:  upc_nx = ret;
                G2_CALL: begin
                    upc_nx   = {1'b0, tgt};
                    save_ret = 1'b1;
                end
                G2_TCALL: if (cond) begin
                    upc_nx   = {1'b0, tgt};
                    save_ret = 1'b1;
                end
                default: upc_nx = upc_inc;
            endcase
        end
    end

    // Phase toggle and end-of-microinstruction register updates
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= 1'b0;
            upc   <= '0;
            ret   <= '0;
            ir    <= '0;
            inte  <= 1'b0;
        end else begin
            phase <= ~phase;
            if (phase) begin
                upc <= upc_nx;
                if (save_ret)         ret  <= upc_inc;
                if (g1 == G1_DECODE)  ir   <= din;
                if (g1 == G1_EI)      inte <= 1'b1;
                else if (g1 == G1_DI) inte <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/useq_core.sv
// Top of the microprogram sequencer: store, field split, strobe decode and
// sequencing state. Store contents come from the PROG and JT parameters.
module useq_core
    import useq_pkg::*;
#(
    parameter logic [HALF*WORD_W-1:0] PROG = {HALF{END_WORD}},
    parameter logic [HALF*TGT_W-1:0]  JT   = {HALF{8'd3}}
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [OPC_W-1:0]    din,
    input  logic                cond,
    output logic [UADDR_W-1:0]  uaddr,
    output logic [WORD_W-1:0]   uword,
    output logic                phase,
    output logic                vma,
    output logic                io,
    output logic                rd,
    output logic                wr,
    output logic                aux_sel,
    output logic                clr_t1,
    output logic                set_acy,
    output logic                ld_al,
    output logic                inte,
    output logic [OPC_W-1:0]    ir
);
    logic [UADDR_W-1:0] ret_q;
    grp1_e              g1;
    grp2_e              g2;

    // Field split of the current word
    assign g1 = grp1_e'(uword[G1_HI -: 3]);
    assign g2 = grp2_e'(uword[G2_HI -: 3]);

    useq_rom #(.PROG(PROG), .JT(JT)) u_rom (
        .addr (uaddr),
        .word (uword)
    );

    useq_flagdec u_dec (
        .phase   (phase),
        .g1      (g1),
        .g2      (g2),
        .b_addr  (uword[BIT_ADDR]),
        .b_al    (uword[BIT_AL]),
        .vma     (vma),
        .io      (io),
        .rd      (rd),
        .wr      (wr),
        .aux_sel (aux_sel),
        .clr_t1  (clr_t1),
        .set_acy (set_acy),
        .ld_al   (ld_al)
    );

    useq_next u_next (
        .clk   (clk),
        .rst_n (rst_n),
        .g1    (g1),
        .g2    (g2),
        .tgt   (word_target(uword)),
        .din   (din),
        .cond  (cond),
        .upc   (uaddr),
        .ret   (ret_q),
        .ir    (ir),
        .phase (phase),
        .inte  (inte)
    );
endmodule

// File: rtl/useq_core_chk.sv
// Checker for useq_core: decodes the observed word on its own and relates
// it to the following microaddress and to the strobe timing.
module useq_core_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [7:0]  din,
    input logic        cond,
    input logic [8:0]  uaddr,
    input logic [31:0] uword,
    input logic        phase,
    input logic        vma,
    input logic        io,
    input logic        rd,
    input logic        wr,
    input logic        aux_sel,
    input logic        clr_t1,
    input logic        set_acy,
    input logic        ld_al,
    input logic        inte
);
    logic [2:0] c1, c2;
    logic       flow_free;
    assign c1 = uword[31:29];
    assign c2 = uword[28:26];
    assign flow_free = (c1 != 3'b001) && (c1 != 3'b111);

    AST_PHASE_ALT: assert property (@(posedge clk) disable iff (!rst_n)
        !phase |=> phase);                                                // R2
    AST_UADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !phase |=> $stable(uaddr));                                       // R2
    AST_SEQ_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (phase && flow_free && (c2 == 3'b000 || c2 == 3'b101 || c2 == 3'b110))
        |=> uaddr == $past(uaddr) + 9'd1);                                // R3
    AST_END_VEC: assert property (@(posedge clk) disable iff (!rst_n)
        (phase && flow_free && c2 == 3'b001) |=> uaddr == 9'd3);          // R4
    AST_HALT_VEC: assert property (@(posedge clk) disable iff (!rst_n)
        (phase && c1 == 3'b111) |=> uaddr == 9'd7);                       // R5
    AST_CALL_TGT: assert property (@(posedge clk) disable iff (!rst_n)
        (phase && flow_free && (c2 == 3'b010 || (c2 == 3'b100 && cond)))
        |=> uaddr == {1'b0, $past(uword[11:10]), $past(uword[5:0])});     // R6
    AST_TCALL_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        (phase && flow_free && c2 == 3'b100 && !cond)
        |=> uaddr == $past(uaddr) + 9'd1);                                // R7
    AST_DECODE_VEC: assert property (@(posedge clk) disable iff (!rst_n)
        (phase && c1 == 3'b001) |=> uaddr == {1'b1, $past(din)});         // R9
    AST_MEM_PH0: assert property (@(posedge clk) disable iff (!rst_n)
        (vma || io) |-> !phase);                                          // R11
    AST_RW_PH1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd || wr) |-> phase);                                            // R11
    AST_EI_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (phase && c1 == 3'b011) |=> inte);                                // R12
    AST_DI_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (phase && c1 == 3'b010) |=> !inte);                               // R12
    AST_AUX_PH0: assert property (@(posedge clk) disable iff (!rst_n)
        (aux_sel || clr_t1 || set_acy || ld_al) |-> !phase);              // R13
endmodule

bind useq_core useq_core_chk u_chk (
    .clk(clk), .rst_n(rst_n), .din(din), .cond(cond), .uaddr(uaddr),
    .uword(uword), .phase(phase), .vma(vma), .io(io), .rd(rd), .wr(wr),
    .aux_sel(aux_sel), .clr_t1(clr_t1), .set_acy(set_acy), .ld_al(ld_al),
    .inte(inte)
);

// File: tb/useq_core_bench.sv
// Bench: a program with a dispatch table, walked one microinstruction per
// vector, then directed checks for the instruction register and reset.
module useq_core_bench;
    import useq_pkg::*;

    function automatic logic [WORD_W-1:0] mk(input logic [2:0] a, input logic [2:0] b);
        mk = {a, b, 26'd0};
    endfunction

    function automatic logic [HALF*WORD_W-1:0] build_prog();
        logic [HALF*WORD_W-1:0] p;
        p = {HALF{END_WORD}};
        p[8'h00*32 +: 32] = mk(3'b011, 3'b000) | 32'h0100_0000;
        p[8'h01*32 +: 32] = mk(3'b001, 3'b000);
        p[8'h03*32 +: 32] = mk(3'b001, 3'b000);
        p[8'h07*32 +: 32] = mk(3'b000, 3'b011);
        p[8'h40*32 +: 32] = mk(3'b000, 3'b101) | 32'h0200_0000;
        p[8'h41*32 +: 32] = mk(3'b100, 3'b110);
        p[8'h42*32 +: 32] = call_word(G2_CALL, 8'h90);
        p[8'h90*32 +: 32] = mk(3'b010, 3'b011);
        p[8'h43*32 +: 32] = call_word(G2_TCALL, 8'hA0);
        p[8'h80*32 +: 32] = call_word(G2_TCALL, 8'hA0);
        p[8'hA0*32 +: 32] = mk(3'b101, 3'b111);
        p[8'hA1*32 +: 32] = mk(3'b110, 3'b011);
        p[8'h81*32 +: 32] = mk(3'b111, 3'b000);
        return p;
    endfunction

    function automatic logic [HALF*TGT_W-1:0] build_jt();
        logic [HALF*TGT_W-1:0] j;
        j = {HALF{8'd3}};
        j[8'h00*8 +: 8] = 8'h40;
        j[8'h5A*8 +: 8] = 8'h80;
        return j;
    endfunction

    localparam logic [HALF*WORD_W-1:0] B_PROG = build_prog();
    localparam logic [HALF*TGT_W-1:0]  B_JT   = build_jt();

    logic clk = 1'b0, rst_n = 1'b0, cond = 1'b0;
    logic [7:0] din = 8'h00;
    logic [8:0] uaddr;
    logic [31:0] uword;
    logic phase, vma, io, rd, wr, aux_sel, clr_t1, set_acy, ld_al, inte;
    logic [7:0] ir;
    int errors = 0, checks = 0, cycles = 0;
    logic done = 1'b0;

    always #5 clk = ~clk;

    useq_core #(.PROG(B_PROG), .JT(B_JT)) u_useq_core (
        .clk(clk), .rst_n(rst_n), .din(din), .cond(cond), .uaddr(uaddr),
        .uword(uword), .phase(phase), .vma(vma), .io(io), .rd(rd), .wr(wr),
        .aux_sel(aux_sel), .clr_t1(clr_t1), .set_acy(set_acy), .ld_al(ld_al),
        .inte(inte), .ir(ir)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Vector: {din[26:19], cond[18], uaddr[17:9],
    //          {vma,io,rd,wr,aux,clrt1,setacy,ld_al}[8:1], inte[0]}
    localparam int NV = 19;
    localparam logic [26:0] VEC [NV] = '{
        {8'h00, 1'b0, 9'h000, 8'b00000001, 1'b0},  // R12 ei, R13 ld_al
        {8'h00, 1'b0, 9'h001, 8'b00000000, 1'b1},  // R9 decode 0x00
        {8'h00, 1'b0, 9'h100, 8'b00000000, 1'b1},  // R9 dispatch call
        {8'h00, 1'b0, 9'h040, 8'b10100000, 1'b1},  // R11 vma, rd
        {8'h00, 1'b0, 9'h041, 8'b01010000, 1'b1},  // R11 io, wr; R3
        {8'h00, 1'b0, 9'h042, 8'b00000000, 1'b1},  // R6 call 0x90
        {8'h00, 1'b0, 9'h090, 8'b00000000, 1'b1},  // R8 return, R12 di
        {8'h00, 1'b0, 9'h043, 8'b00000000, 1'b0},  // R7 not taken
        {8'h00, 1'b0, 9'h044, 8'b00000000, 1'b0},  // R10 default end word
        {8'hFF, 1'b0, 9'h003, 8'b00000000, 1'b0},  // R4 end vector, decode 0xFF
        {8'h00, 1'b0, 9'h1FF, 8'b00000000, 1'b0},  // R9 last table entry
        {8'h5A, 1'b0, 9'h003, 8'b00000000, 1'b0},  // decode 0x5A
        {8'h00, 1'b0, 9'h15A, 8'b00000000, 1'b0},
        {8'h00, 1'b1, 9'h080, 8'b00000000, 1'b0},  // R7 taken
        {8'h00, 1'b0, 9'h0A0, 8'b00001010, 1'b0},  // R13 aux, setacy
        {8'h00, 1'b0, 9'h0A1, 8'b00000100, 1'b0},  // R13 clrt1, R8
        {8'h00, 1'b0, 9'h081, 8'b00000000, 1'b0},  // R5 halt
        {8'h00, 1'b0, 9'h007, 8'b00000000, 1'b0},  // R5 vector, return
        {8'h00, 1'b0, 9'h081, 8'b00000000, 1'b0}   // R5 return register kept
    };

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000 && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<=5000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 uaddr", {23'd0, uaddr}, 32'd0);
        chk("R1 phase", {31'd0, phase}, 32'd0);
        chk("R1 inte",  {31'd0, inte}, 32'd0);
        chk("R1 ir",    {24'd0, ir}, 32'd0);
        for (int i = 0; i < NV; i++) begin
            din  = VEC[i][26:19];
            cond = VEC[i][18];
            chk($sformatf("R2/R3 step%0d uaddr", i), {23'd0, uaddr}, {23'd0, VEC[i][17:9]});
            chk($sformatf("R11/R13 step%0d ph0", i),
                {24'd0, vma, io, rd, wr, aux_sel, clr_t1, set_acy, ld_al},
                {24'd0, VEC[i][8:7], 2'b00, VEC[i][4:1]});
            chk($sformatf("R12 step%0d inte", i), {31'd0, inte}, {31'd0, VEC[i][0]});
            @(negedge clk);
            chk($sformatf("R2 step%0d held", i), {23'd0, uaddr}, {23'd0, VEC[i][17:9]});
            chk($sformatf("R11 step%0d ph1", i),
                {24'd0, vma, io, rd, wr, aux_sel, clr_t1, set_acy, ld_al},
                {26'd0, VEC[i][6:5], 4'd0});
            @(negedge clk);
        end
        // Directed: instruction register holds last decoded opcode (R9)
        chk("R9 ir", {24'd0, ir}, 32'h5A);
        // Directed: reset in the middle of a run (R1)
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 re-reset uaddr", {23'd0, uaddr}, 32'd0);
        chk("R1 re-reset ir", {24'd0, ir}, 32'd0);
        chk("R1 re-reset phase", {31'd0, phase}, 32'd0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule